// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block decides when a transmitter may start or restart a frame on an Ethernet link. It sits beside the transmit datapath. It watches carrier sense and collision, and it issues a one-cycle start permit once the inter-packet gap has elapsed on a quiet medium. When a collision hits a transmission in half-duplex mode, the block truncates the frame by asserting a jam-enable for a fixed jam length, during which the datapath sends zero bytes. It then counts the collision and waits a random number of slot times before it retries. The random number comes from a free-running LFSR, captured at the collision and masked to a width that grows with the attempt number up to a cap. A no-backoff mode skips the random wait and retries straight after the gap. After the last allowed attempt the frame is dropped with an excessive-collision pulse.

In full-duplex mode, carrier sense and collision have no effect, and the gap uses its own programmable value. Software can also force a jam onto a busy medium in half-duplex mode.

The block is clocked once per bit time. `slot_tick_i` strobes once per slot time. Every input is synchronous to `clk`.

State machine (`hdx_state_e`):
- **IDLE**: waits for a pending frame, or for a forced jam.
  - Goes to FJAM on `force_jam_i` with carrier in half duplex.
  - Goes to GAP on `tx_req_i`.
- **GAP**: counts the inter-packet gap. In half duplex, carrier reloads the count.
  - Goes to START when the count is exhausted.
- **START**: issues the permit strobe.
  - Goes to XMIT unconditionally.
- **XMIT**: the frame is on the wire.
  - Goes to IDLE on `tx_done_i`, which clears the attempt count.
  - Goes to JAM on a half-duplex collision, which bumps the count and captures the random slot count.
- **JAM**: drives jam for `JAM_BITS` cycles. When the jam ends:
  - Goes to ABORT if the count is at its limit.
  - Otherwise goes to GAP if no-backoff is set.
  - Otherwise goes to BACKOFF.
- **BACKOFF**: spends the captured number of slot ticks.
  - Goes to GAP when the slot count is zero.
- **ABORT**: issues the excessive-collision pulse and clears the count.
  - Goes to IDLE.
- **FJAM**: forced jam.
  - Goes to IDLE once the force request or the carrier drops, or once full duplex is selected.

Top module: `hdx_backoff_ctrl`

## Requirements
- R1: While reset is held and after its release, `tx_start_o`, `jam_o` and `excess_col_o` are 0 and `attempt_o` is 0.
- R2: The start strobe lasts exactly one cycle. With a quiet medium, it first appears G+2 cycles after `tx_req_i` is sampled high in IDLE. G is `ipg_hdx_i` in half duplex and `ipg_fdx_i` in full duplex.
- R3: In half duplex, carrier during the gap restarts it, and the strobe appears G+1 cycles after carrier falls. In full duplex, carrier is ignored.
- R4: A collision in half duplex during transmission raises `jam_o` in the following cycle for exactly `JAM_BITS` (32) cycles, and `attempt_o` increases by one at the jam's start.
- R5: With backoff enabled, after collision n the strobe appears at least G+1 cycles and at most G+2+2^k·P cycles after the jam ends. Here k = min(n,10) and P is the slot-tick period in cycles.
- R6: With no-backoff set, the strobe appears exactly G+1 cycles after the jam ends.
- R7: In full duplex, `col_i` during transmission raises no jam and leaves `attempt_o` unchanged.
- R8: In IDLE and half duplex, `force_jam_i` together with `crs_i` raises `jam_o` one cycle later. The jam holds while both stay high and falls one cycle after either drops. In full duplex, or without carrier, the request has no effect.
- R9: The jam that ends the 16th collision of a frame is followed by a one-cycle `excess_col_o` with `attempt_o` = 16. After that, `attempt_o` is 0 and no retry strobe follows.
- R10: `tx_done_i` during transmission clears `attempt_o` to 0 one cycle later.
- R11: When `tx_done_i` and `col_i` are high in the same transmit cycle, the success wins: no jam, and `attempt_o` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex_i | input | 1 | 1 selects full duplex |
| no_backoff_i | input | 1 | 1 skips the random slot wait |
| force_jam_i | input | 1 | Software request to jam a busy medium |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision detect |
| slot_tick_i | input | 1 | One-cycle strobe per slot time |
| ipg_hdx_i | input | IPG_W | Gap length for half duplex, in cycles |
| ipg_fdx_i | input | IPG_W | Gap length for full duplex, in cycles |
| tx_req_i | input | 1 | A frame is waiting to go out |
| tx_done_i | input | 1 | The current frame finished cleanly |
| tx_start_o | output | 1 | Start or restart permit strobe |
| jam_o | output | 1 | Replace transmit data with zero jam |
| attempt_o | output | ATT_W | Collisions so far on the current frame |
| excess_col_o | output | 1 | Frame dropped after too many collisions |

## Verification
The checker takes it that `tx_done_i` arrives only while a frame is in transmission and that `force_jam_i` stays low during a collision jam. Otherwise a forced jam could stretch a collision jam past its bound unseen. It also takes it that duplex mode does not flip in the cycle before a jam starts. The directed scenarios keep to these rules: every input changes on the falling edge, and done is raised only after the permit strobe has been seen. The forced-jam case runs from IDLE with no frame pending, and duplex is changed only while the block is idle.

// File: rtl/hdx_backoff_pkg.sv
package hdx_backoff_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_START,
        ST_XMIT,
        ST_JAM,
        ST_BACKOFF,
        ST_ABORT,
        ST_FJAM
    } hdx_state_e;

endpackage

// File: rtl/hdx_lfsr.sv
// Free-running Fibonacci LFSR; never holds the all-zero word.
module hdx_lfsr #(
    parameter int               W    = 10,
    parameter logic [W-1:0]     TAPS = 10'h240,
    parameter logic [W-1:0]     SEED = 10'h1A5
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd_o
);

    logic [W-1:0] lfsr_q;
    logic         fb;

    assign fb = ^(lfsr_q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= {lfsr_q[W-2:0], fb};
        end
    end

    assign rnd_o = lfsr_q;

endmodule

// File: rtl/hdx_down_cnt.sv
// Loadable down counter that stops at zero.
module hdx_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/hdx_backoff_ctrl.sv
module hdx_backoff_ctrl
    import hdx_backoff_pkg::*;
#(
    parameter int IPG_W         = 8,
    parameter int JAM_BITS      = 32,
    parameter int MAX_ATTEMPTS  = 16,
    parameter int BACKOFF_LIMIT = 10,
    parameter int LFSR_W        = 10,
    localparam int ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_duplex_i,
    input  logic             no_backoff_i,
    input  logic             force_jam_i,
    input  logic             crs_i,
    input  logic             col_i,
    input  logic             slot_tick_i,
    input  logic [IPG_W-1:0] ipg_hdx_i,
    input  logic [IPG_W-1:0] ipg_fdx_i,
    input  logic             tx_req_i,
    input  logic             tx_done_i,
    output logic             tx_start_o,
    output logic             jam_o,
    output logic [ATT_W-1:0] attempt_o,
    output logic             excess_col_o
);

    localparam int JAM_W  = $clog2(JAM_BITS);
    localparam int TMR_W  = (IPG_W > JAM_W) ? IPG_W : JAM_W;
    localparam int SLOT_W = BACKOFF_LIMIT;

    hdx_state_e state_q, state_d;

    logic [ATT_W-1:0]  attempt_q;
    logic              att_inc, att_clr;

    logic              tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0]  tmr_val, tmr_cnt;
    logic              slot_load, slot_dec, slot_zero;
    logic [SLOT_W-1:0] slot_val, slot_cnt;

    logic [LFSR_W-1:0] rnd;
    logic              hdx, carrier, fjam_req;
    logic [TMR_W-1:0]  gap_val;
    logic [ATT_W-1:0]  next_att;
    logic [ATT_W-1:0]  exp_k;
    logic [SLOT_W-1:0] slot_mask;

    assign hdx      = !full_duplex_i;
    assign carrier  = hdx && crs_i;
    assign fjam_req = hdx && force_jam_i && crs_i;
    assign gap_val  = full_duplex_i ? TMR_W'(ipg_fdx_i) : TMR_W'(ipg_hdx_i);

    // Exponent k = min(attempt number, cap); mask keeps k low bits.
    assign next_att  = attempt_q + 1'b1;
    assign exp_k     = (next_att > ATT_W'(BACKOFF_LIMIT)) ? ATT_W'(BACKOFF_LIMIT) : next_att;
    assign slot_mask = (SLOT_W'(1) << exp_k) - SLOT_W'(1);
    assign slot_val  = rnd[SLOT_W-1:0] & slot_mask;

    hdx_lfsr #(
        .W (LFSR_W)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    // Shared timer: inter-packet gap and jam length.
    hdx_down_cnt #(
        .W (TMR_W)
    ) u_gap_jam_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .cnt_o      (tmr_cnt),
        .zero_o     (tmr_zero)
    );

    // Backoff slot counter.
    hdx_down_cnt #(
        .W (SLOT_W)
    ) u_slot_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (slot_load),
        .load_val_i (slot_val),
        .dec_i      (slot_dec),
        .cnt_o      (slot_cnt),
        .zero_o     (slot_zero)
    );

    // State and attempt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            attempt_q <= '0;
        end else begin
            state_q <= state_d;
            if (att_clr) begin
                attempt_q <= '0;
            end else if (att_inc) begin
                attempt_q <= next_att;
            end
        end
    end

    // Transitions and counter control.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = gap_val;
        tmr_dec   = 1'b0;
        slot_load = 1'b0;
        slot_dec  = 1'b0;
        att_inc   = 1'b0;
        att_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fjam_req) begin
                    state_d = ST_FJAM;
                end else if (tx_req_i) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                end
            end
            ST_GAP: begin
                if (carrier) begin
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    state_d = ST_START;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_START: begin
                state_d = ST_XMIT;
            end
            ST_XMIT: begin
                if (tx_done_i) begin
                    state_d = ST_IDLE;
                    att_clr = 1'b1;
                end else if (hdx && col_i) begin
                    state_d   = ST_JAM;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(JAM_BITS - 1);
                    att_inc   = 1'b1;
                    slot_load = 1'b1;
                end
            end
            ST_JAM: begin
                if (!tmr_zero) begin
                    tmr_dec = 1'b1;
                end else if (attempt_q == ATT_W'(MAX_ATTEMPTS)) begin
                    state_d = ST_ABORT;
                end else if (no_backoff_i) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                end else begin
                    state_d = ST_BACKOFF;
                end
            end
            ST_BACKOFF: begin
                if (slot_zero) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                end else begin
                    slot_dec = slot_tick_i;
                end
            end
            ST_ABORT: begin
                state_d = ST_IDLE;
                att_clr = 1'b1;
            end
            ST_FJAM: begin
                if (!fjam_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        tx_start_o   = 1'b0;
        jam_o        = 1'b0;
        excess_col_o = 1'b0;
        unique case (state_q)
            ST_START: tx_start_o   = 1'b1;
            ST_JAM:   jam_o        = 1'b1;
            ST_FJAM:  jam_o        = 1'b1;
            ST_ABORT: excess_col_o = 1'b1;
            default: ;
        endcase
    end

    assign attempt_o = attempt_q;

endmodule

// File: rtl/hdx_backoff_chk.sv
module hdx_backoff_chk #(
    parameter int MAX_ATTEMPTS = 16,
    parameter int JAM_BITS     = 32,
    localparam int ATT_W       = $clog2(MAX_ATTEMPTS + 1),
    localparam int RUN_W       = $clog2(JAM_BITS + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             full_duplex_i,
    input logic             force_jam_i,
    input logic             tx_start_o,
    input logic             jam_o,
    input logic [ATT_W-1:0] attempt_o,
    input logic             excess_col_o
);

    logic [RUN_W-1:0] jam_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jam_run_q <= '0;
        end else if (!jam_o || force_jam_i) begin
            jam_run_q <= '0;
        end else if (jam_run_q != RUN_W'(JAM_BITS + 1)) begin
            jam_run_q <= jam_run_q + 1'b1;
        end
    end

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |=> !tx_start_o);

    p_start_not_jam_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start_o && jam_o));

    p_jam_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jam_run_q <= RUN_W'(JAM_BITS));

    p_att_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt_o != $past(attempt_o)) |->
            ((attempt_o == $past(attempt_o) + 1'b1) || (attempt_o == '0)));

    p_att_inc_jam_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((attempt_o != $past(attempt_o)) && (attempt_o != '0)) |-> $rose(jam_o));

    p_jam_hdx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_o) |-> !$past(full_duplex_i));

    p_excess_at_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        excess_col_o |-> (attempt_o == ATT_W'(MAX_ATTEMPTS)));

    p_excess_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        excess_col_o |=> ((attempt_o == '0) && !excess_col_o));

endmodule

bind hdx_backoff_ctrl hdx_backoff_chk #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .JAM_BITS     (JAM_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .full_duplex_i (full_duplex_i),
    .force_jam_i   (force_jam_i),
    .tx_start_o    (tx_start_o),
    .jam_o         (jam_o),
    .attempt_o     (attempt_o),
    .excess_col_o  (excess_col_o)
);

// File: tb/hdx_backoff_ctrl_tb_top.sv
module hdx_backoff_ctrl_tb_top;

    localparam int GH   = 12;
    localparam int GF   = 20;
    localparam int P    = 3;
    localparam int JAM  = 32;
    localparam int MAXA = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       full_duplex_i = 1'b0;
    logic       no_backoff_i = 1'b0;
    logic       force_jam_i = 1'b0;
    logic       crs_i = 1'b0;
    logic       col_i = 1'b0;
    logic       slot_tick_i = 1'b0;
    logic [7:0] ipg_hdx_i = 8'(GH);
    logic [7:0] ipg_fdx_i = 8'(GF);
    logic       tx_req_i = 1'b0;
    logic       tx_done_i = 1'b0;
    logic       tx_start_o;
    logic       jam_o;
    logic [4:0] attempt_o;
    logic       excess_col_o;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    hdx_backoff_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .full_duplex_i (full_duplex_i),
        .no_backoff_i  (no_backoff_i),
        .force_jam_i   (force_jam_i),
        .crs_i         (crs_i),
        .col_i         (col_i),
        .slot_tick_i   (slot_tick_i),
        .ipg_hdx_i     (ipg_hdx_i),
        .ipg_fdx_i     (ipg_fdx_i),
        .tx_req_i      (tx_req_i),
        .tx_done_i     (tx_done_i),
        .tx_start_o    (tx_start_o),
        .jam_o         (jam_o),
        .attempt_o     (attempt_o),
        .excess_col_o  (excess_col_o)
    );

    // Slot strobe every P cycles.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            slot_tick_i = (ph == 0);
            ph = (ph + 1) % P;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    // Counts posedges until the start strobe is seen at a falling edge.
    task automatic wait_start(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!tx_start_o && n < 20000);
    endtask

    // Called at the negedge showing START; collides in XMIT; returns at jam fall.
    task automatic collide(output int len, output int att);
        @(negedge clk);
        col_i = 1'b1;
        @(negedge clk);
        col_i = 1'b0;
        att = int'(attempt_o);
        len = 0;
        while (jam_o && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    // Called at the negedge showing START; finishes the frame.
    task automatic finish_ok();
        @(negedge clk);
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 start in reset", int'(tx_start_o), 0);
        chk("R1 jam in reset", int'(jam_o), 0);
        chk("R1 attempt in reset", int'(attempt_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 excess after reset", int'(excess_col_o), 0);
        chk("R1 attempt after reset", int'(attempt_o), 0);
    endtask

    task automatic t_gap();
        int n;
        full_duplex_i = 1'b0;
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        chk("R2 hdx gap", n, GH + 2);
        @(negedge clk);
        chk("R2 strobe one cycle", int'(tx_start_o), 0);
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
        full_duplex_i = 1'b1;
        @(negedge clk);
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        chk("R2 fdx gap", n, GF + 2);
        finish_ok();
        full_duplex_i = 1'b0;
    endtask

    task automatic t_defer();
        int n;
        bit seen = 0;
        crs_i = 1'b1;
        tx_req_i = 1'b1;
        for (int i = 0; i < GH + 10; i++) begin
            @(negedge clk);
            if (tx_start_o) seen = 1;
        end
        chk("R3 no start under carrier", int'(seen), 0);
        crs_i = 1'b0;
        wait_start(n);
        tx_req_i = 1'b0;
        chk("R3 hdx gap after carrier", n, GH + 1);
        finish_ok();
        full_duplex_i = 1'b1;
        crs_i = 1'b1;
        @(negedge clk);
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        chk("R3 fdx ignores carrier", n, GF + 2);
        finish_ok();
        crs_i = 1'b0;
        full_duplex_i = 1'b0;
    endtask

    task automatic t_no_backoff();
        int n, len, att;
        no_backoff_i = 1'b1;
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        collide(len, att);
        chk("R4 jam length", len, JAM);
        chk("R4 attempt after collision", att, 1);
        wait_start(n);
        chk("R6 retry after gap", n, GH + 1);
        finish_ok();
        chk("R10 attempt cleared", int'(attempt_o), 0);
        no_backoff_i = 1'b0;
    endtask

    task automatic t_backoff();
        int n, len, att, k;
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        for (int c = 1; c <= 12; c++) begin
            collide(len, att);
            chk("R4 jam length backoff", len, JAM);
            chk("R4 attempt count", att, c);
            k = (c < 10) ? c : 10;
            wait_start(n);
            chk_rng("R5 backoff delay", n, GH + 1, GH + 2 + (1 << k) * P);
        end
        finish_ok();
        chk("R10 attempt cleared after backoff", int'(attempt_o), 0);
    endtask

    task automatic t_fdx_col();
        int n;
        bit jam_seen = 0;
        full_duplex_i = 1'b1;
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        @(negedge clk);
        col_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (jam_o) jam_seen = 1;
        end
        col_i = 1'b0;
        @(negedge clk);
        if (jam_o) jam_seen = 1;
        chk("R7 no jam in fdx", int'(jam_seen), 0);
        chk("R7 attempt unchanged in fdx", int'(attempt_o), 0);
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
        full_duplex_i = 1'b0;
    endtask

    task automatic t_done_beats_col();
        int n, len, att;
        no_backoff_i = 1'b1;
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        collide(len, att);
        wait_start(n);
        @(negedge clk);
        col_i = 1'b1;
        tx_done_i = 1'b1;
        @(negedge clk);
        col_i = 1'b0;
        tx_done_i = 1'b0;
        chk("R11 no jam when done wins", int'(jam_o), 0);
        chk("R11 attempt cleared when done wins", int'(attempt_o), 0);
        no_backoff_i = 1'b0;
    endtask

    task automatic t_excess();
        int n, len, att;
        bit seen = 0;
        no_backoff_i = 1'b1;
        tx_req_i = 1'b1;
        wait_start(n);
        tx_req_i = 1'b0;
        for (int c = 1; c < MAXA; c++) begin
            collide(len, att);
            wait_start(n);
        end
        collide(len, att);
        chk("R9 last attempt count", att, MAXA);
        chk("R9 excess pulse", int'(excess_col_o), 1);
        chk("R9 attempt at abort", int'(attempt_o), MAXA);
        @(negedge clk);
        chk("R9 excess one cycle", int'(excess_col_o), 0);
        chk("R9 attempt reset", int'(attempt_o), 0);
        for (int i = 0; i < GH + 6; i++) begin
            @(negedge clk);
            if (tx_start_o) seen = 1;
        end
        chk("R9 no retry after abort", int'(seen), 0);
        no_backoff_i = 1'b0;
    endtask

    task automatic t_force();
        force_jam_i = 1'b1;
        @(negedge clk);
        chk("R8 force without carrier", int'(jam_o), 0);
        crs_i = 1'b1;
        @(negedge clk);
        chk("R8 forced jam starts", int'(jam_o), 1);
        repeat (4) @(negedge clk);
        chk("R8 forced jam held", int'(jam_o), 1);
        force_jam_i = 1'b0;
        @(negedge clk);
        chk("R8 forced jam ends", int'(jam_o), 0);
        full_duplex_i = 1'b1;
        force_jam_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 no forced jam in fdx", int'(jam_o), 0);
        force_jam_i = 1'b0;
        crs_i = 1'b0;
        full_duplex_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_gap();
        t_defer();
        t_no_backoff();
        t_backoff();
        t_fdx_col();
        t_done_beats_col();
        t_excess();
        t_force();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule